// File: doc/BRIEF.md
# UART Interrupt Mask and Routing

This block is the interrupt register group of a memory-mapped UART. Eleven raw event bits are held in a level register. The FIFO, transmitter, modem and error logic around the block set these bits with one-cycle pulses. Software clears them by writing ones to a write-only clear register, and chooses which events may raise a line through an enable mask.

The masked level is split into fixed bit groups. Each group drives its own dedicated line: receive, transmit, receive timeout, modem status and error. A combined line is raised when any enabled bit of any group is set.

Access is through a 32-bit register port addressed by word offset. The port also carries the transmit data write strobe, which raises the transmit event. It also holds the FIFO level select register, which the FIFO logic reads.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the mask and level registers read zero and all six lines are low.
- R2: A one on bit i of `set_pulse` sets level bit i, and the bit holds until it is cleared. The bit layout is: 0 ring indicator, 1 CTS, 2 DCD, 3 DSR, 4 receive, 5 transmit, 6 receive timeout, 7 framing, 8 parity, 9 break, 10 overrun.
- R3: A write to offset 0 (transmit data) sets level bit 5.
- R4: A write to offset 5 (clear) clears each level bit whose written bit is one. A set pulse in the same cycle wins over the clear. A read of offset 5 returns zero.
- R5: Offset 2 reads and writes the 11-bit mask. Offset 3 reads the level register. Offset 4 reads the level ANDed with the mask.
- R6: Writes to offsets 3 and 4, and to unmapped offsets, change no register. Reads of unmapped offsets and of offset 0 return zero.
- R7: `irq_rx`, `irq_tx` and `irq_rt` are masked bits 4, 5 and 6. `irq_ms` is the OR of masked bits 3:0. `irq_err` is the OR of masked bits 10:7.
- R8: `irq_comb` is the OR of all eleven masked bits.
- R9: The lines are registered. They take their new value on the same clock edge that captures a set pulse, mask write or clear write.
- R10: Offset 1 is a 6-bit FIFO level select register. It resets to 0x12 and its upper written bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational on `reg_addr` |
| set_pulse | input | 11 | Event set pulses, one per level bit |
| irq_comb | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rt | output | 1 | Receive timeout interrupt |
| irq_ms | output | 1 | Modem status interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
A corrupted level or mask bit shows up on the line of its group, and on the combined line, at the very next clock edge. It can also be read back at offsets 3 and 4 in the same cycle the address is presented. The reference model therefore compares all six lines on every cycle, and compares read data whenever a read is made. A clear that removes the wrong bits, or a set that loses to a clear, diverges from the model within one cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NSRC = 11;
   localparam int NLINE = 6;

   localparam int B_RI  = 0;
   localparam int B_CTS = 1;
   localparam int B_DCD = 2;
   localparam int B_DSR = 3;
   localparam int B_RX  = 4;
   localparam int B_TX  = 5;
   localparam int B_RT  = 6;
   localparam int B_FE  = 7;
   localparam int B_PE  = 8;
   localparam int B_BE  = 9;
   localparam int B_OE  = 10;

   localparam logic [NSRC-1:0] GRP_MS  = 11'h00F;
   localparam logic [NSRC-1:0] GRP_ERR = 11'h780;
   localparam logic [NSRC-1:0] GRP_RX  = 11'h010;
   localparam logic [NSRC-1:0] GRP_TX  = 11'h020;
   localparam logic [NSRC-1:0] GRP_RT  = 11'h040;

   // line order: 0 combined, 1 rx, 2 tx, 3 rt, 4 ms, 5 err
   localparam logic [NSRC-1:0] LINE_GRP [NLINE] = '{
      GRP_ERR | GRP_MS | GRP_RT | GRP_TX | GRP_RX,
      GRP_RX, GRP_TX, GRP_RT, GRP_MS, GRP_ERR};

   typedef enum logic [2:0] {
      OFS_TXDATA = 3'd0,
      OFS_FLSEL  = 3'd1,
      OFS_MASK   = 3'd2,
      OFS_RAW    = 3'd3,
      OFS_MASKED = 3'd4,
      OFS_CLEAR  = 3'd5
   } reg_ofs_e;
endpackage

// File: rtl/uart_irq_field.sv
module uart_irq_field #(
   parameter int W = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_nxt
);
   initial begin
      if (W < 1) $error("uart_irq_field: W must be at least 1");
   end

   always_comb q_nxt = we ? d : q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST;
      else        q <= q_nxt;
   end
endmodule

// File: rtl/uart_irq_level.sv
module uart_irq_level #(
   parameter int N = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] lvl_q,
   output logic [N-1:0] lvl_nxt
);
   // a set in the same cycle as a clear wins
   always_comb lvl_nxt = (lvl_q & ~clr_i) | set_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_nxt;
   end
endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route
   import uart_irq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] lvl_nxt,
   input  logic [NSRC-1:0] mask_nxt,
   output logic [NLINE-1:0] line_q
);
   logic [NSRC-1:0] active;
   always_comb active = lvl_nxt & mask_nxt;

   for (genvar g = 0; g < NLINE; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line_q[g] <= 1'b0;
         else        line_q[g] <= |(active & LINE_GRP[g]);
      end
   end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int FLS_W  = 6,
   parameter logic [FLS_W-1:0] FLS_RST = 6'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NSRC-1:0]   set_pulse,
   output logic              irq_comb,
   output logic              irq_rx,
   output logic              irq_tx,
   output logic              irq_rt,
   output logic              irq_ms,
   output logic              irq_err
);
   localparam logic [ADDR_W-1:0] A_TX  = ADDR_W'(OFS_TXDATA);
   localparam logic [ADDR_W-1:0] A_FLS = ADDR_W'(OFS_FLSEL);
   localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(OFS_RAW);
   localparam logic [ADDR_W-1:0] A_MIS = ADDR_W'(OFS_MASKED);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLEAR);

   initial begin
      if (ADDR_W < 3) $error("uart_irq_ctrl: ADDR_W must be at least 3");
      if (DATA_W < NSRC) $error("uart_irq_ctrl: DATA_W narrower than level");
      if (FLS_W > DATA_W) $error("uart_irq_ctrl: FLS_W wider than DATA_W");
   end

   logic [NSRC-1:0]  lvl_q, lvl_nxt, mask_q, mask_nxt, clr_v, set_v;
   logic [FLS_W-1:0] fls_q, fls_nxt;
   logic [NLINE-1:0] line_q;

   always_comb begin
      clr_v = (reg_wr && reg_addr == A_CLR) ? reg_wdata[NSRC-1:0] : '0;
      set_v = set_pulse;
      if (reg_wr && reg_addr == A_TX) set_v[B_TX] = 1'b1;
   end

   uart_irq_level #(.N(NSRC)) u_level (
      .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v),
      .lvl_q(lvl_q), .lvl_nxt(lvl_nxt));

   uart_irq_field #(.W(NSRC), .RST('0)) u_mask (
      .clk(clk), .rst_n(rst_n), .we(reg_wr && reg_addr == A_MSK),
      .d(reg_wdata[NSRC-1:0]), .q(mask_q), .q_nxt(mask_nxt));

   uart_irq_field #(.W(FLS_W), .RST(FLS_RST)) u_fls (
      .clk(clk), .rst_n(rst_n), .we(reg_wr && reg_addr == A_FLS),
      .d(reg_wdata[FLS_W-1:0]), .q(fls_q), .q_nxt(fls_nxt));

   uart_irq_route u_route (
      .clk(clk), .rst_n(rst_n), .lvl_nxt(lvl_nxt), .mask_nxt(mask_nxt),
      .line_q(line_q));

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_FLS:   reg_rdata = DATA_W'(fls_q);
         A_MSK:   reg_rdata = DATA_W'(mask_q);
         A_RAW:   reg_rdata = DATA_W'(lvl_q);
         A_MIS:   reg_rdata = DATA_W'(lvl_q & mask_q);
         default: reg_rdata = '0;
      endcase
   end

   assign irq_comb = line_q[0];
   assign irq_rx   = line_q[1];
   assign irq_tx   = line_q[2];
   assign irq_rt   = line_q[3];
   assign irq_ms   = line_q[4];
   assign irq_err  = line_q[5];
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
   import uart_irq_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [NSRC-1:0]   set_pulse,
   input logic [NSRC-1:0]   lvl,
   input logic [NSRC-1:0]   mask,
   input logic              irq_comb,
   input logic              irq_rx,
   input logic              irq_err
);
   logic wr_clr, wr_tx, wr_ro;
   assign wr_clr = reg_wr && reg_addr == ADDR_W'(OFS_CLEAR);
   assign wr_tx  = reg_wr && reg_addr == ADDR_W'(OFS_TXDATA);
   assign wr_ro  = reg_wr && (reg_addr == ADDR_W'(OFS_RAW) ||
                              reg_addr == ADDR_W'(OFS_MASKED));

   // R2
   set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(set_pulse) != '0 |-> (lvl & $past(set_pulse)) == $past(set_pulse));

   // R3
   tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(wr_tx) |-> lvl[B_TX]);

   // R4
   clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(wr_clr) |->
         (lvl & $past(reg_wdata[NSRC-1:0]) & ~$past(set_pulse)) == '0);

   // R4
   clr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr == ADDR_W'(OFS_CLEAR) |-> reg_rdata == '0);

   // R6
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(wr_ro) && $past(set_pulse) == '0 |->
         lvl == $past(lvl) && mask == $past(mask));

   // R7
   rx_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> irq_rx == (lvl[B_RX] & mask[B_RX]));

   // R7
   err_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> irq_err == |(lvl & mask & GRP_ERR));

   // R8
   comb_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> irq_comb == |(lvl & mask));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_pulse(set_pulse),
   .lvl(lvl_q), .mask(mask_q), .irq_comb(irq_comb), .irq_rx(irq_rx),
   .irq_err(irq_err));

// File: tb/tb_uart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [10:0] set_pulse = '0;
   logic irq_comb, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // reference model state
   int m_lvl = 0;
   int m_mask = 0;
   int m_fls = 'h12;

   always #5 clk = ~clk;

   uart_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_pulse(set_pulse),
      .irq_comb(irq_comb), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rt(irq_rt),
      .irq_ms(irq_ms), .irq_err(irq_err));

   function automatic int exp_read(input int a);
      case (a)
         1: return m_fls;
         2: return m_mask;
         3: return m_lvl;
         4: return m_lvl & m_mask;
         default: return 0;
      endcase
   endfunction

   task automatic check_lines();
      int act = m_lvl & m_mask;
      logic [5:0] e, g;
      e[0] = act != 0;
      e[1] = act[4];
      e[2] = act[5];
      e[3] = act[6];
      e[4] = (act & 'h00F) != 0;
      e[5] = (act & 'h780) != 0;
      g = {irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_comb};
      checks++;
      if (g !== e) begin
         errors++;
         $display("FAIL R7 R8 R9 lines {err,ms,rt,tx,rx,comb}: actual %b expected %b", g, e);
      end
   endtask

   task automatic step(input bit wr, input int a, input int wd, input int st,
                       input bit rd, input string req);
      @(negedge clk);
      check_lines();
      reg_wr = wr;
      reg_addr = 4'(a);
      reg_wdata = 32'(wd);
      set_pulse = 11'(st);
      #1;
      if (rd) begin
         checks++;
         if (reg_rdata !== 32'(exp_read(a))) begin
            errors++;
            $display("FAIL %s read offset %0d: actual %h expected %h",
                     req, a, reg_rdata, exp_read(a));
         end
      end
      @(posedge clk);
      if (wr) begin
         case (a)
            0: m_lvl = m_lvl | 'h20;
            1: m_fls = wd & 'h3F;
            2: m_mask = wd & 'h7FF;
            5: m_lvl = m_lvl & ~(wd & 'h7FF);
            default: ;
         endcase
      end
      m_lvl = m_lvl | (st & 'h7FF);
      #1;
      reg_wr = 1'b0;
      set_pulse = '0;
   endtask

   task automatic rd(input int a, input string req);
      step(1'b0, a, 0, 0, 1'b1, req);
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int lf = 32'h1ACE;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 / R10 reset values
      rd(2, "R1");
      rd(3, "R1");
      rd(4, "R1");
      rd(1, "R10");
      // R2 set with mask off: raw holds, lines stay low
      step(1'b0, 3, 0, 'h010, 1'b0, "R2");
      rd(3, "R2");
      rd(4, "R5");
      // R5 mask write and read back
      step(1'b1, 2, 'hFFFF_FFFF, 0, 1'b0, "R5");
      rd(2, "R5");
      rd(4, "R5");
      // R6 read-only and unmapped writes ignored
      step(1'b1, 3, 0, 0, 1'b0, "R6");
      step(1'b1, 4, 0, 0, 1'b0, "R6");
      step(1'b1, 7, 'h7FF, 0, 1'b0, "R6");
      rd(3, "R6");
      rd(2, "R6");
      rd(7, "R6");
      rd(0, "R6");
      // R4 clear and clear read
      step(1'b1, 5, 'h010, 0, 1'b0, "R4");
      rd(5, "R4");
      rd(3, "R4");
      // R3 transmit data write
      step(1'b1, 0, 'h41, 0, 1'b0, "R3");
      rd(3, "R3");
      // R4 set wins over same-cycle clear
      step(1'b1, 5, 'h7FF, 'h080, 1'b0, "R4");
      rd(3, "R4");
      // R7 walk each bit through its own line
      for (int i = 0; i < 11; i++) begin
         step(1'b1, 5, 'h7FF, 0, 1'b0, "R7");
         step(1'b1, 2, 1 << i, 0, 1'b0, "R7");
         step(1'b0, 0, 0, 1 << i, 1'b0, "R7");
         rd(4, "R7");
         step(1'b1, 2, 0, 0, 1'b0, "R9");
      end
      // R10 level select width
      step(1'b1, 1, 'hFF, 0, 1'b0, "R10");
      rd(1, "R10");
      // mixed traffic against the model (R8 R9)
      for (int k = 0; k < 400; k++) begin
         lf = (lf << 1) ^ ((lf[31] ^ lf[21] ^ lf[1] ^ lf[0]) ? 1 : 0);
         step(lf[3], lf[6:4], lf ^ (lf >> 9), lf[2] ? (lf >> 13) : 0,
              1'b1, "R8");
      end
      step(1'b0, 0, 0, 0, 1'b0, "R9");
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule